// File: doc/BRIEF.md
# Asynchronous Schedule Advance Doorbell

This block runs the handshake that tells software when it may reuse the memory of queue heads it has just unlinked from a circular asynchronous schedule. Software unlinks one or more queue heads and then writes 1 to a doorbell bit. While the request is pending, the doorbell reads 1. The block then watches the traversal engine, which raises a one-cycle pulse each time it reaches the list head.

Once the engine has come back to the head the required number of times (two by default), no cached reference to the old list can remain. At that point the block sets an advance-status bit and clears the doorbell. It can also raise an interrupt. The status bit stays set until software writes 1 to clear it. Software must clear the status bit before it rings the doorbell again. A doorbell write that arrives while the status bit is still set is dropped and reported on a protocol-error pulse.

If the schedule is switched off while a request is pending, there is nothing left to drain, so the request completes at the next edge.

Top module: `async_adv_doorbell`

## Requirements
- R1: After a synchronous active-low reset, `doorbell`, `adv_sts`, `irq` and `proto_err` all read 0.
- R2: A cycle with `db_wr`=1 and `db_wdata`=1, while `doorbell`=0 and `adv_sts`=0, makes `doorbell` read 1 from the next cycle. A write with `db_wdata`=0 never clears a pending doorbell.
- R3: While `doorbell`=1, each cycle with `head_seen`=1 counts one pass. At the edge where the count reaches PASSES (2 by default), `adv_sts` reads 1 from the next cycle. Fewer passes leave `adv_sts` at 0.
- R4: `doorbell` returns to 0 in the same cycle in which `adv_sts` first reads 1.
- R5: `adv_sts` stays 1 until a cycle with `sts_wr`=1 and `sts_wdata`=1. A status write with `sts_wdata`=0 leaves it unchanged.
- R6: If a completion and a status clear fall in the same cycle, the completion wins and `adv_sts` reads 1.
- R7: `irq` equals `adv_sts` AND `irq_en` combinationally, in the same cycle.
- R8: If `sched_en`=0 in a cycle with `doorbell`=1, the request completes at that edge: `adv_sts`=1 and `doorbell`=0 on the next cycle.
- R9: A doorbell write of 1 while `adv_sts`=1 is ignored: `doorbell` stays 0 and `proto_err` reads 1 for exactly the next cycle.
- R10: A doorbell write of 1 while `doorbell` is already 1 is ignored and does not restart the pass count.
- R11: Head pulses seen while `doorbell`=0, including the cycle of the accepting write, are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| db_wr | input | 1 | Command-register write strobe for the doorbell bit |
| db_wdata | input | 1 | Value written to the doorbell bit |
| sts_wr | input | 1 | Status-register write strobe |
| sts_wdata | input | 1 | Value written to the status bit (1 clears it) |
| irq_en | input | 1 | Interrupt enable for advance status |
| sched_en | input | 1 | Asynchronous schedule enabled |
| head_seen | input | 1 | One-cycle pulse when traversal reaches the list head |
| doorbell | output | 1 | Doorbell bit, 1 while a request is pending |
| adv_sts | output | 1 | Advance-status bit |
| irq | output | 1 | Interrupt request |
| proto_err | output | 1 | One-cycle pulse for a doorbell write made while status was set |

## Verification
The bench builds the block with the default PASSES of 2, which gives a 2-bit pass counter. With this value, a run of only a few head pulses pushes the counter to saturation. It also brings within reach the boundary between the first and second pass, where R3, R10 and R11 differ. Random head pulses, schedule disables and overlapping writes land on every ordering of accept, count, complete and clear, including the same-cycle set-versus-clear race of R6.

// File: rtl/adv_db_pkg.sv
// Package: shared types for the advance doorbell block.
// Assumes: register writes arrive as a strobe plus a single data bit.
package adv_db_pkg;

    // One software write to a single-bit register field.
    typedef struct packed {
        logic strobe;
        logic value;
    } bit_write_t;

    // Returns 1 when the write sets the field to one.
    function automatic logic writes_one(bit_write_t w);
        return w.strobe & w.value;
    endfunction

endpackage

// File: rtl/head_pass_counter.sv
// Counts list-head passes for one pending doorbell request.
// Assumes: clear and step never need to be honoured in the same cycle
// (the controller only clears on accept, when no request is pending).
// The count saturates at PASSES and holds until the next clear.
module head_pass_counter #(
    parameter int PASSES = 2,
    localparam int W = $clog2(PASSES + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         final_pass
);
    localparam logic [W-1:0] LAST = W'(PASSES - 1);
    localparam logic [W-1:0] TOP  = W'(PASSES);

    // The current step completes the required number of passes.
    assign final_pass = step && (count == LAST);

    // Saturating pass counter with restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (clear)                  count <= '0;
        else if (step && (count != TOP)) count <= count + 1'b1;
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TOP);

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> $stable(count));
endmodule

// File: rtl/doorbell_ctl.sv
// Holds the doorbell and advance-status bits.
// Assumes: pass_done is a pulse qualified by a pending request.
// A doorbell write of 1 is accepted only when nothing is pending and the
// status bit is clear. The status is set on completion, which takes
// priority over a same-cycle write-one-to-clear.
module doorbell_ctl
    import adv_db_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bit_write_t db_w,
    input  bit_write_t sts_w,
    input  logic       sched_en,
    input  logic       pass_done,
    output logic       accept,
    output logic       doorbell,
    output logic       adv_sts,
    output logic       proto_err
);
    logic ring;
    logic finish;
    logic ack;

    // Decode the software writes.
    assign ring   = writes_one(db_w);
    assign ack    = writes_one(sts_w);
    assign accept = ring && !doorbell && !adv_sts;

    // A pending request ends on the final pass or when the schedule is off.
    assign finish = doorbell && (pass_done || !sched_en);

    // Doorbell bit: set on accept, self-clears on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      doorbell <= 1'b0;
        else if (accept) doorbell <= 1'b1;
        else if (finish) doorbell <= 1'b0;
    end

    // Status bit: set on completion, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)      adv_sts <= 1'b0;
        else if (finish) adv_sts <= 1'b1;
        else if (ack)    adv_sts <= 1'b0;
    end

    // Flag a doorbell write made before the status was acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= ring && adv_sts;
    end

    // R4
    sts_clears_db_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adv_sts) |-> $fell(doorbell));

    // R4
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv_sts && doorbell));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring && !doorbell && !adv_sts) |=> doorbell);

    // R8
    sched_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (doorbell && !sched_en) |=> (adv_sts && !doorbell));

    // R9
    proto_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring && adv_sts) |=> (proto_err && !doorbell));

    // R5
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_sts && !ack) |=> adv_sts);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && ack) |=> adv_sts);
endmodule

// File: rtl/async_adv_doorbell.sv
// Top of the asynchronous schedule advance doorbell handshake.
// Assumes: head_seen is a one-cycle pulse from the traversal engine.
// Status is raised after PASSES head passes since the doorbell was
// accepted, or at once when the schedule is disabled.
module async_adv_doorbell
    import adv_db_pkg::*;
#(
    parameter int PASSES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic db_wr,
    input  logic db_wdata,
    input  logic sts_wr,
    input  logic sts_wdata,
    input  logic irq_en,
    input  logic sched_en,
    input  logic head_seen,
    output logic doorbell,
    output logic adv_sts,
    output logic irq,
    output logic proto_err
);
    localparam int CW = $clog2(PASSES + 1);

    bit_write_t     db_w;
    bit_write_t     sts_w;
    logic           accept;
    logic           pass_done;
    logic [CW-1:0]  pass_cnt;

    // Bundle the register writes.
    assign db_w  = '{strobe: db_wr,  value: db_wdata};
    assign sts_w = '{strobe: sts_wr, value: sts_wdata};

    head_pass_counter #(.PASSES(PASSES)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .step       (doorbell && head_seen),
        .count      (pass_cnt),
        .final_pass (pass_done)
    );

    doorbell_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .db_w      (db_w),
        .sts_w     (sts_w),
        .sched_en  (sched_en),
        .pass_done (pass_done),
        .accept    (accept),
        .doorbell  (doorbell),
        .adv_sts   (adv_sts),
        .proto_err (proto_err)
    );

    // Interrupt follows the gated status.
    assign irq = adv_sts & irq_en;

    // R11
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!doorbell && !accept) |=> $stable(pass_cnt));
endmodule

// File: tb/async_adv_doorbell_test.sv
module async_adv_doorbell_test;
    localparam int PASSES = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic db_wr = 0, db_wdata = 0, sts_wr = 0, sts_wdata = 0;
    logic irq_en = 0, sched_en = 1, head_seen = 0;
    logic doorbell, adv_sts, irq, proto_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference state
    bit m_db = 0, m_sts = 0, m_err = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    async_adv_doorbell #(.PASSES(PASSES)) uut (
        .clk(clk), .rst_n(rst_n), .db_wr(db_wr), .db_wdata(db_wdata),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .irq_en(irq_en),
        .sched_en(sched_en), .head_seen(head_seen), .doorbell(doorbell),
        .adv_sts(adv_sts), .irq(irq), .proto_err(proto_err)
    );

    task automatic check(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Next model state, from the requirements.
    function automatic void model_step();
        bit ring, acc, ack, done;
        ring = db_wr && db_wdata;
        acc  = ring && !m_db && !m_sts;
        ack  = sts_wr && sts_wdata;
        done = m_db && ((head_seen && m_cnt == PASSES - 1) || !sched_en);
        m_err = ring && m_sts;
        if (acc) m_cnt = 0;
        else if (m_db && head_seen && m_cnt < PASSES) m_cnt++;
        if (done) m_sts = 1;
        else if (ack) m_sts = 0;
        if (acc) m_db = 1;
        else if (done) m_db = 0;
    endfunction

    // Apply one cycle of inputs, then compare all outputs with the model.
    task automatic step(string tag, bit dw, bit dd, bit sw, bit sd,
                        bit ie, bit se, bit hs);
        db_wr = dw; db_wdata = dd; sts_wr = sw; sts_wdata = sd;
        irq_en = ie; sched_en = se; head_seen = hs;
        #1;
        check("R7", "irq same cycle", irq, m_sts & ie);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, "doorbell", doorbell, m_db);
        check(tag, "adv_sts", adv_sts, m_sts);
        check(tag, "proto_err", proto_err, m_err);
        check("R7", "irq", irq, m_sts & ie);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 1, 1, 0);
    endtask

    task automatic clear_sts();
        step("R5", 0, 0, 1, 1, 1, 1, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "doorbell", doorbell, 0);
        check("R1", "adv_sts", adv_sts, 0);
        check("R1", "irq", irq, 0);
        check("R1", "proto_err", proto_err, 0);
        rst_n = 1;
        idle("R1", 2);

        // R11: head pulses before and during the accepting write are not counted
        step("R11", 0, 0, 0, 0, 1, 1, 1);
        step("R11", 1, 1, 0, 0, 1, 1, 1);
        check("R2", "doorbell pending", doorbell, 1);
        step("R3", 0, 0, 0, 0, 1, 1, 1);
        check("R3", "one pass not enough", adv_sts, 0);
        // R2: writing 0 does not cancel
        step("R2", 1, 0, 0, 0, 1, 1, 0);
        check("R2", "write 0 keeps doorbell", doorbell, 1);
        step("R3", 0, 0, 0, 0, 1, 1, 1);
        check("R3", "second pass sets status", adv_sts, 1);
        check("R4", "doorbell self-clears", doorbell, 0);
        check("R7", "irq enabled", irq, 1);
        step("R7", 0, 0, 0, 0, 0, 1, 0);
        check("R7", "irq masked", irq, 0);

        // R9: ring while status set
        step("R9", 1, 1, 0, 0, 1, 1, 1);
        check("R9", "error pulse", proto_err, 1);
        check("R9", "doorbell ignored", doorbell, 0);
        idle("R9", 1);
        check("R9", "error one cycle", proto_err, 0);
        // R5: write 0 then write 1
        step("R5", 0, 0, 1, 0, 1, 1, 0);
        check("R5", "write 0 keeps status", adv_sts, 1);
        clear_sts();
        check("R5", "write 1 clears", adv_sts, 0);

        // R10: re-ring while pending does not restart the count
        step("R10", 1, 1, 0, 0, 1, 1, 0);
        step("R10", 0, 0, 0, 0, 1, 1, 1);
        step("R10", 1, 1, 0, 0, 1, 1, 0);
        step("R10", 0, 0, 0, 0, 1, 1, 1);
        check("R10", "completes after two passes total", adv_sts, 1);
        clear_sts();

        // R8: schedule disabled while pending
        step("R8", 1, 1, 0, 0, 1, 1, 0);
        step("R8", 0, 0, 0, 0, 1, 0, 0);
        check("R8", "status set", adv_sts, 1);
        check("R8", "doorbell clear", doorbell, 0);
        clear_sts();

        // R6: completion and clear in the same cycle
        step("R6", 1, 1, 0, 0, 1, 1, 0);
        step("R6", 0, 0, 0, 0, 1, 1, 1);
        step("R6", 0, 0, 1, 1, 1, 1, 1);
        check("R6", "set wins", adv_sts, 1);
        clear_sts();

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            bit dw, dd, sw, sd, ie, se, hs;
            dw = ($urandom % 8) == 0;
            dd = ($urandom % 4) != 0;
            sw = ($urandom % 6) == 0;
            sd = ($urandom % 3) != 0;
            ie = $urandom % 2;
            se = ($urandom % 16) != 0;
            hs = ($urandom % 4) == 0;
            step("R3", dw, dd, sw, sd, ie, se, hs);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule